// File: doc/BRIEF.md
# Rate-1/3 Turbo Encoder with Quadratic Permutation Interleaver

This block turns a bit-serial transport block of K bits into three coded output streams. The first stream repeats the input bits. The second stream is the parity of a recursive systematic convolutional encoder that reads the bits in their natural order. The third stream is the parity of an identical encoder that reads the bits in quadratic-permutation order. Each constituent encoder has three delay registers (8 states). Its feedback polynomial is 1 + D^2 + D^3 and its feedforward polynomial is 1 + D + D^3.

A block begins with a one-cycle `start`. That cycle presents the block length and the two permutation coefficients. The K input bits then arrive one per cycle while `in_valid` is high, and gaps between bits are allowed. The whole block is held in an internal bit store, because the permuted encoder needs random access to it. Once the last bit has arrived, the encoder emits K data triples on consecutive cycles. The permuted read addresses come from an incremental modulo-K recurrence, so no divider is needed. Both encoders are then flushed by feeding their own feedback back into them. The twelve termination bits leave as four more triples, and a one-cycle `done` marks the end of the block.

Top module: `turbo_enc_qpp`

## Requirements
- R1: After reset, and until a block has been loaded, `out_valid` and `done` stay low.
- R2: The first K triples of a block carry the input bits on `out_sys`, in arrival order, on K consecutive cycles.
- R3: For those K triples, `out_par1` is the parity of the constituent encoder fed with input bit k. The encoder's feedback is 1+D^2+D^3, its parity is 1+D+D^3, and its registers start at zero.
- R4: For those K triples, `out_par2` is the parity of the same kind of encoder fed with input bit pi(k), where pi(k) = (f1*k + f2*k*k) mod K. This requires f1 < K and f2 < K.
- R5: Each block yields exactly K+4 valid triples: K data triples, then four tail triples.
- R6: Tail order, with x/z as the flush input/parity of the first encoder and x'/z' those of the second. Tail triple 0 is (x_K, z_K, x_K+1). Triple 1 is (z_K+1, x_K+2, z_K+2). Triple 2 is (x'_K, z'_K, x'_K+1). Triple 3 is (z'_K+1, x'_K+2, z'_K+2). Each triple is listed as (out_sys, out_par1, out_par2).
- R7: Every block starts both encoders from all-zero registers, whatever the previous block contained. After the flush, both encoders hold zero.
- R8: `done` is high for exactly one cycle, the cycle right after the last tail triple, and `out_valid` is low in that cycle.
- R9: `start` is ignored unless the block is idle. `in_valid` is ignored unless input bits are being collected. Idle cycles inside the input phase are allowed.
- R10: Any K from 40 up to the parameter KMAX (default 6144) is encoded correctly, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a block; sampled only while idle |
| k_len | input | KW | Block length K, sampled with start |
| f1 | input | KW | Linear permutation coefficient, below K |
| f2 | input | KW | Quadratic permutation coefficient, below K |
| in_valid | input | 1 | Qualifies in_bit during the input phase |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Output triple valid |
| out_sys | output | 1 | Stream 0: systematic bit or tail bit |
| out_par1 | output | 1 | Stream 1: natural-order parity or tail bit |
| out_par2 | output | 1 | Stream 2: permuted-order parity or tail bit |
| done | output | 1 | One-cycle end-of-block pulse |

## Verification
The encoder is driven with five kinds of block:
- **All zeros.** This must give all-zero parity and tail bits.
- **All ones.** This exercises the feedback path in its steady state.
- **A single one at index 0, or at index K-1.** A one at the start shows the full impulse response. A one at the end shows up only in the tail, and in the permuted stream at the position where pi maps to it.
- **Pseudo-random bits.** These catch wrong permutation steps and any mix-up among the twelve tail positions.

A zero block run straight after an all-ones block tells a correct per-block clear apart from leftover encoder state. One run adds idle input cycles, plus stray `start` and `in_valid` pulses during encoding. Lengths include the smallest and the largest K.

// File: rtl/tenc_pkg.sv
package tenc_pkg;
    localparam int unsigned RSC_REGS     = 3;
    localparam int unsigned FLUSH_STEPS  = 3;
    localparam int unsigned TAIL_TRIPLES = 4;
    localparam int unsigned TAIL_BITS    = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_ENC,
        ST_FLUSH,
        ST_TAIL,
        ST_DONE
    } tenc_state_e;
endpackage

// File: rtl/tenc_rsc.sv
module tenc_rsc
    import tenc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic                step,
    input  logic                term,
    input  logic                u,
    output logic                x,
    output logic                z,
    output logic [RSC_REGS-1:0] st
);
    // st_q[0] holds D^1, st_q[1] D^2, st_q[2] D^3
    logic [RSC_REGS-1:0] st_d, st_q;
    logic fb;

    always_comb begin
        // while flushing, the input equals the feedback so the register input is 0
        x    = term ? (st_q[1] ^ st_q[2]) : u;
        fb   = x ^ st_q[1] ^ st_q[2];
        z    = fb ^ st_q[0] ^ st_q[2];
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (step) begin
            st_d = {st_q[1], st_q[0], fb};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/tenc_qpp_gen.sv
module tenc_qpp_gen #(
    parameter int unsigned KW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          adv,
    input  logic [KW-1:0] k_len,
    input  logic [KW-1:0] f1,
    input  logic [KW-1:0] f2,
    output logic [KW-1:0] pi
);
    typedef struct packed {
        logic [KW-1:0] k;
        logic [KW-1:0] pi;
        logic [KW-1:0] g;
        logic [KW-1:0] gstep;
    } qpp_t;

    qpp_t r_d, r_q;

    function automatic logic [KW-1:0] addmod(logic [KW-1:0] a, logic [KW-1:0] b,
                                             logic [KW-1:0] m);
        logic [KW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[KW-1:0];
    endfunction

    always_comb begin
        r_d = r_q;
        if (init) begin
            r_d.k     = k_len;
            r_d.pi    = '0;
            r_d.g     = addmod(f1, f2, k_len);
            r_d.gstep = addmod(f2, f2, k_len);
        end else if (adv) begin
            r_d.pi = addmod(r_q.pi, r_q.g, r_q.k);
            r_d.g  = addmod(r_q.g, r_q.gstep, r_q.k);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign pi = r_q.pi;
endmodule

// File: rtl/tenc_bitbuf.sv
module tenc_bitbuf #(
    parameter int unsigned KMAX = 6144,
    parameter int unsigned KW   = 13
) (
    input  logic          clk,
    input  logic          we,
    input  logic [KW-1:0] wa,
    input  logic          wd,
    input  logic [KW-1:0] ra0,
    input  logic [KW-1:0] ra1,
    output logic          rd0,
    output logic          rd1
);
    localparam int unsigned WW    = 32;
    localparam int unsigned LW    = $clog2(WW);
    localparam int unsigned WORDS = (KMAX + WW - 1) / WW;
    localparam int unsigned AW    = (WORDS > 1) ? $clog2(WORDS) : 1;

    logic [WW-1:0] mem [WORDS];
    logic [AW-1:0] w_word, r0_word, r1_word;

    assign w_word  = AW'(wa >> LW);
    assign r0_word = AW'(ra0 >> LW);
    assign r1_word = AW'(ra1 >> LW);

    always_ff @(posedge clk) begin
        if (we) mem[w_word][wa[LW-1:0]] <= wd;
    end

    assign rd0 = mem[r0_word][ra0[LW-1:0]];
    assign rd1 = mem[r1_word][ra1[LW-1:0]];
endmodule

// File: rtl/turbo_enc_qpp.sv
module turbo_enc_qpp
    import tenc_pkg::*;
#(
    parameter int unsigned KMAX = 6144,
    parameter int unsigned KW   = $clog2(KMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [KW-1:0] k_len,
    input  logic [KW-1:0] f1,
    input  logic [KW-1:0] f2,
    input  logic          in_valid,
    input  logic          in_bit,
    output logic          out_valid,
    output logic          out_sys,
    output logic          out_par1,
    output logic          out_par2,
    output logic          done
);
    localparam int unsigned NENC = 2;
    localparam int unsigned HALF = TAIL_BITS / 2;

    typedef struct packed {
        tenc_state_e          st;
        logic [KW-1:0]        k;
        logic [KW-1:0]        wr;
        logic [KW-1:0]        rd;
        logic [1:0]           cnt;
        logic [TAIL_BITS-1:0] tail;
        logic                 ov;
        logic                 o0;
        logic                 o1;
        logic                 o2;
        logic                 done;
    } regs_t;

    regs_t r_d, r_q;

    logic                c_clr, c_step, c_term;
    logic [NENC-1:0]     c_u, c_x, c_z;
    logic [RSC_REGS-1:0] c_st [NENC];
    logic                buf_we, rd_nat, rd_perm;
    logic                q_init, q_adv;
    logic [KW-1:0]       pi;
    tenc_state_e         st_w;
    logic [KW-1:0]       k_w;

    tenc_bitbuf #(.KMAX(KMAX), .KW(KW)) u_buf (
        .clk (clk),
        .we  (buf_we),
        .wa  (r_q.wr),
        .wd  (in_bit),
        .ra0 (r_q.rd),
        .ra1 (pi),
        .rd0 (rd_nat),
        .rd1 (rd_perm)
    );

    tenc_qpp_gen #(.KW(KW)) u_qpp (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (q_init),
        .adv   (q_adv),
        .k_len (k_len),
        .f1    (f1),
        .f2    (f2),
        .pi    (pi)
    );

    assign c_u = {rd_perm, rd_nat};

    for (genvar gi = 0; gi < NENC; gi++) begin : g_rsc
        tenc_rsc u_rsc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (c_clr),
            .step  (c_step),
            .term  (c_term),
            .u     (c_u[gi]),
            .x     (c_x[gi]),
            .z     (c_z[gi]),
            .st    (c_st[gi])
        );
    end

    always_comb begin
        r_d      = r_q;
        r_d.ov   = 1'b0;
        r_d.done = 1'b0;
        c_clr    = 1'b0;
        c_step   = 1'b0;
        c_term   = 1'b0;
        buf_we   = 1'b0;
        q_init   = 1'b0;
        q_adv    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.k  = k_len;
                    r_d.wr = '0;
                    r_d.st = ST_LOAD;
                    c_clr  = 1'b1;
                    q_init = 1'b1;
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    buf_we = 1'b1;
                    r_d.wr = r_q.wr + KW'(1);
                    if (r_q.wr == r_q.k - KW'(1)) begin
                        r_d.st = ST_ENC;
                        r_d.rd = '0;
                    end
                end
            end
            ST_ENC: begin
                c_step = 1'b1;
                q_adv  = 1'b1;
                r_d.ov = 1'b1;
                r_d.o0 = rd_nat;
                r_d.o1 = c_z[0];
                r_d.o2 = c_z[1];
                r_d.rd = r_q.rd + KW'(1);
                if (r_q.rd == r_q.k - KW'(1)) begin
                    r_d.st  = ST_FLUSH;
                    r_d.cnt = '0;
                end
            end
            ST_FLUSH: begin
                c_step   = 1'b1;
                c_term   = 1'b1;
                // upper half collects the first encoder, lower half the second
                r_d.tail = {r_q.tail[TAIL_BITS-3:HALF], c_x[0], c_z[0],
                            r_q.tail[HALF-3:0], c_x[1], c_z[1]};
                r_d.cnt  = r_q.cnt + 2'd1;
                if (r_q.cnt == 2'(FLUSH_STEPS - 1)) begin
                    r_d.st  = ST_TAIL;
                    r_d.cnt = '0;
                end
            end
            ST_TAIL: begin
                r_d.ov   = 1'b1;
                {r_d.o0, r_d.o1, r_d.o2} = r_q.tail[TAIL_BITS-1 -: 3];
                r_d.tail = {r_q.tail[TAIL_BITS-4:0], 3'b000};
                r_d.cnt  = r_q.cnt + 2'd1;
                if (r_q.cnt == 2'(TAIL_TRIPLES - 1)) r_d.st = ST_DONE;
            end
            ST_DONE: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_w      = r_q.st;
    assign k_w       = r_q.k;
    assign out_valid = r_q.ov;
    assign out_sys   = r_q.o0;
    assign out_par1  = r_q.o1;
    assign out_par2  = r_q.o2;
    assign done      = r_q.done;
endmodule

// File: rtl/turbo_enc_qpp_chk.sv
module turbo_enc_qpp_chk
    import tenc_pkg::*;
#(
    parameter int unsigned KW = 13
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [KW-1:0]       k_len,
    input tenc_state_e         st,
    input logic [KW-1:0]       k_q,
    input logic [KW-1:0]       pi,
    input logic [RSC_REGS-1:0] st_a,
    input logic [RSC_REGS-1:0] st_b,
    input logic                out_valid,
    input logic                done
);
    logic [KW:0]   vcnt;
    logic [KW-1:0] k_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vcnt   <= '0;
            k_seen <= '0;
        end else if (st == ST_IDLE && start) begin
            vcnt   <= '0;
            k_seen <= k_len;
        end else if (out_valid) begin
            vcnt <= vcnt + (KW+1)'(1);
        end
    end

    a_r5_triple_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (vcnt == {1'b0, k_seen} + (KW+1)'(TAIL_TRIPLES)));

    a_r5_valid_framing: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (st != ST_IDLE && st != ST_LOAD));

    a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && $past(out_valid)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_pi_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ENC) |-> (pi < k_q));

    a_r7_flushed_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TAIL) |-> (st_a == '0 && st_b == '0));
endmodule

bind turbo_enc_qpp turbo_enc_qpp_chk #(.KW(KW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .k_len     (k_len),
    .st        (st_w),
    .k_q       (k_w),
    .pi        (pi),
    .st_a      (c_st[0]),
    .st_b      (c_st[1]),
    .out_valid (out_valid),
    .done      (done)
);

// File: tb/test_turbo_enc_qpp.sv
`timescale 1ns/1ps
module test_turbo_enc_qpp;
    localparam int KMAX = 6144;
    localparam int KW   = $clog2(KMAX + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [KW-1:0] k_len = '0;
    logic [KW-1:0] f1 = '0;
    logic [KW-1:0] f2 = '0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic          out_valid, out_sys, out_par1, out_par2, done;

    always #4 clk = ~clk;

    turbo_enc_qpp #(.KMAX(KMAX)) i_turbo_enc_qpp (
        .clk(clk), .rst_n(rst_n), .start(start), .k_len(k_len), .f1(f1), .f2(f2),
        .in_valid(in_valid), .in_bit(in_bit), .out_valid(out_valid),
        .out_sys(out_sys), .out_par1(out_par1), .out_par2(out_par2), .done(done)
    );

    int checks = 0;
    int errors = 0;
    bit din [KMAX];
    bit ex0 [KMAX+4];
    bit ex1 [KMAX+4];
    bit ex2 [KMAX+4];

    // K, f1, f2, pattern (0 zeros, 1 ones, 2 one at index 0, 3 one at K-1, 4 random, 5 random+junk)
    localparam int NV = 8;
    localparam int TAB [NV][4] = '{
        '{40,   3,   10,  4},
        '{48,   7,   12,  1},
        '{40,   3,   10,  0},
        '{64,   7,   16,  2},
        '{56,   19,  42,  3},
        '{104,  7,   26,  5},
        '{512,  31,  64,  4},
        '{6144, 263, 480, 4}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // D^1 in s[0], D^2 in s[1], D^3 in s[2]
    task automatic rsc(inout bit [2:0] s, input bit u, output bit z);
        bit w;
        w = u ^ s[1] ^ s[2];
        z = w ^ s[0] ^ s[2];
        s = {s[1], s[0], w};
    endtask

    task automatic build_expected(input int K, input int a1, input int a2);
        bit [2:0] s1, s2;
        bit z, u;
        bit xt1 [3];
        bit zt1 [3];
        bit xt2 [3];
        bit zt2 [3];
        s1 = '0;
        s2 = '0;
        for (int i = 0; i < K; i++) begin
            longint p;
            p = (longint'(a1) * i + longint'(a2) * i * i) % K;
            ex0[i] = din[i];
            rsc(s1, din[i], z); ex1[i] = z;
            rsc(s2, din[int'(p)], z); ex2[i] = z;
        end
        for (int t = 0; t < 3; t++) begin
            u = s1[1] ^ s1[2]; xt1[t] = u; rsc(s1, u, z); zt1[t] = z;
            u = s2[1] ^ s2[2]; xt2[t] = u; rsc(s2, u, z); zt2[t] = z;
        end
        ex0[K]   = xt1[0]; ex1[K]   = zt1[0]; ex2[K]   = xt1[1];
        ex0[K+1] = zt1[1]; ex1[K+1] = xt1[2]; ex2[K+1] = zt1[2];
        ex0[K+2] = xt2[0]; ex1[K+2] = zt2[0]; ex2[K+2] = xt2[1];
        ex0[K+3] = zt2[1]; ex1[K+3] = xt2[2]; ex2[K+3] = zt2[2];
    endtask

    task automatic fill(input int K, input int pat, input int seed);
        bit [15:0] l;
        l = 16'(seed) | 16'h1;
        for (int i = 0; i < K; i++) begin
            case (pat)
                0: din[i] = 1'b0;
                1: din[i] = 1'b1;
                2: din[i] = (i == 0);
                3: din[i] = (i == K - 1);
                default: begin
                    l = l[0] ? ((l >> 1) ^ 16'hB400) : (l >> 1);
                    din[i] = l[0];
                end
            endcase
        end
    endtask

    task automatic drive(input int K, input int a1, input int a2, input bit junk);
        @(negedge clk);
        start = 1'b1; k_len = KW'(K); f1 = KW'(a1); f2 = KW'(a2);
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < K; i++) begin
            if (junk && (i % 3 == 1)) begin
                in_valid = 1'b0; in_bit = 1'b1;   // R9 idle input cycle
                @(negedge clk);
            end
            if (junk && i == 5) begin
                start = 1'b1; k_len = KW'(77); // R9 stray start while loading
            end else begin
                start = 1'b0;
            end
            in_valid = 1'b1; in_bit = din[i];
            @(negedge clk);
        end
        start = 1'b0;
        in_valid = 1'b0;
        if (junk) begin
            for (int j = 0; j < 20; j++) begin   // R9 junk during encoding
                in_valid = 1'b1; in_bit = j[0];
                start = (j == 4);
                k_len = KW'(41);
                @(negedge clk);
            end
            in_valid = 1'b0;
            start = 1'b0;
        end
        k_len = KW'(K);
    endtask

    task automatic collect(input int K, input string tag);
        int  n = 0;
        int  bad = 0;
        bit  prev_ov = 1'b0;
        bit  got_done = 1'b0;
        for (int c = 0; c < 3 * K + 200 && !got_done; c++) begin
            @(negedge clk);
            if (out_valid) begin
                if (n < K + 4) begin
                    if (n < K) begin
                        check(out_sys == ex0[n], "R2", "systematic bit", out_sys, ex0[n]);
                        check(out_par1 == ex1[n], "R3", "parity 1 bit", out_par1, ex1[n]);
                        check(out_par2 == ex2[n], "R4", "parity 2 bit", out_par2, ex2[n]);
                    end else begin
                        check(out_sys == ex0[n], "R6", "tail stream 0", out_sys, ex0[n]);
                        check(out_par1 == ex1[n], "R6", "tail stream 1", out_par1, ex1[n]);
                        check(out_par2 == ex2[n], "R6", "tail stream 2", out_par2, ex2[n]);
                    end
                    if (out_sys != ex0[n] || out_par1 != ex1[n] || out_par2 != ex2[n]) bad++;
                end
                n++;
            end
            if (done) begin
                got_done = 1'b1;
                check(n == K + 4, "R5", "triples per block", n, K + 4);
                check(prev_ov && !out_valid, "R8", "done after last triple",
                      {prev_ov, out_valid}, 2);
            end
            prev_ov = out_valid;
        end
        check(got_done, "R8", "done seen", got_done, 1);
        @(negedge clk);
        check(!done, "R8", "done one cycle", done, 0);
        check(bad == 0, tag, "block mismatches", bad, 0);
    endtask

    task automatic run_block(input int K, input int a1, input int a2, input int pat,
                             input int seed, input string tag);
        fill(K, pat, seed);
        build_expected(K, a1, a2);
        fork
            drive(K, a1, a2, pat == 5);
            collect(K, tag);
        join
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs quiet after reset
        check(out_valid == 1'b0, "R1", "out_valid at reset", out_valid, 0);
        check(done == 1'b0, "R1", "done at reset", done, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0 && done == 1'b0, "R1", "quiet before start",
              {out_valid, done}, 0);

        // R9: in_valid while idle has no effect
        for (int i = 0; i < 8; i++) begin
            in_valid = 1'b1; in_bit = 1'b1;
            @(negedge clk);
            check(out_valid == 1'b0, "R9", "idle in_valid ignored", out_valid, 0);
        end
        in_valid = 1'b0;

        for (int v = 0; v < NV; v++) begin
            string tag;
            if (v == 2) tag = "R7";                       // zeros right after ones
            else if (v == 5) tag = "R9";                  // junk and gaps
            else if (v == 0 || v == NV - 1) tag = "R10";  // smallest and largest K
            else tag = "R4";
            run_block(TAB[v][0], TAB[v][1], TAB[v][2], TAB[v][3], 37 * v + 11, tag);
        end

        // R7: back-to-back impulse blocks with no idle gap
        run_block(40, 3, 10, 3, 5, "R7");
        run_block(40, 3, 10, 2, 5, "R7");
        finish_run();
    end
endmodule